// File: doc/BRIEF.md
# Cascaded Serial Control Word Engine

This block sits on the serial control bus of one switch device inside a two-dimensional array of such devices. It samples a serial data line on every rising edge of the control clock and searches that bit stream for 30-bit control words. Each word carries a 6-bit start pattern, a row address, a column address and four 3-bit output codes. The block passes every word on to two neighbours. One is the next device along the row and the other is the next device down the column. Each path has its own data line and its own forwarded clock. On each path the block reduces one of the two addresses by one, so a word reaches its target with both addresses at zero.

When a write word arrives with both addresses at zero, the block keeps its four output codes in a 12-bit load register and pulses a ready flag. Moving that value into the live switch configuration is done elsewhere. When a read word arrives with both addresses at zero, the block replaces the outgoing code bits with the current configuration supplied at its input. Downstream devices then carry that data back out of the array.

A mode input freezes all internal state and holds both forwarded clocks low.

Top module: `cascade_ctl_engine`

## Requirements
- R1: A word starts when the last six sampled bits equal 6'b011111 (write) or 6'b011110 (read), first bit oldest. The search for a start pattern runs at every sampling edge that is not inside a word. A bit stream that never contains either pattern produces no capture and no address change.
- R2: After a start pattern is accepted, exactly 24 further bits belong to the word. These bits are ordered row address (6, MSB first), column address (6), then four 3-bit codes. A start pattern inside those 24 bits is ignored. The search resumes at the next edge after the 24th bit.
- R3: With mode low, a bit sampled at a rising edge appears on both serial outputs just after the seventh rising edge, counting the sampling edge as the first. Bits that no rule below touches are reproduced unchanged. Both forwarded clocks follow the control clock.
- R4: On the column output, the row address field of each word is reduced by one modulo 64. All other bits of the word are unchanged.
- R5: On the row output, the column address field of each word is reduced by one modulo 64. All other bits of the word are unchanged.
- R6: A write word with row and column both zero stores its 12 code bits in the load register, first received code bit in bit 11. The register changes on the second enabled edge after the last bit of the word, and the ready flag is high for exactly that one enabled cycle.
- R7: A write word with either address nonzero, and every read word, leaves the load register unchanged and the ready flag low.
- R8: A read word with row and column both zero sends the configuration input, bit 11 first, in place of its 12 code bits on both outputs. Because of the normal decrement, the outgoing reduced address is 6'h3F. The next word is again treated by its own start pattern.
- R9: While mode is high, sampling edges change no state and no output, the serial data input is ignored, and both forwarded clocks stay low.
- R10: While reset is asserted, both serial outputs, the load register and the ready flag are zero, and no word is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial control clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | High freezes the engine and holds the forwarded clocks low |
| si | input | 1 | Serial control data in |
| cfg_i | input | 12 | Current switch configuration, returned by a matching read word |
| row_so | output | 1 | Serial data toward the next device in the row |
| row_sclk | output | 1 | Forwarded clock for the row output |
| col_so | output | 1 | Serial data toward the next device in the column |
| col_sclk | output | 1 | Forwarded clock for the column output |
| ld_word | output | 12 | Load register holding the four captured output codes |
| ld_rdy | output | 1 | One-cycle pulse when the load register takes a new value |

## Verification
The bench sends words addressed to this device, to a device further along the row and to a device further down the column. Comparing both output streams bit by bit separates the row-field and column-field decrements and shows whether a zero address wraps to 3F. It also sends patterns that look almost like a start pattern, a payload that contains a start pattern, and words sent back to back with no gap. These show whether the framer resynchronises too early or misses a word. A read with a matching address is followed by a write, and a freeze window is placed in the middle of a word. These check in-stream insertion, the return to write handling, and that a stalled edge loses no bits. A long pseudo-random stream is also compared on every clock against a behavioural model.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  localparam int FRAME_W = 6;
  localparam logic [FRAME_W-1:0] FRM_WR = 6'b011111;
  localparam logic [FRAME_W-1:0] FRM_RD = 6'b011110;

  typedef enum logic {
    KIND_WR = 1'b0,
    KIND_RD = 1'b1
  } word_kind_e;
endpackage

// File: rtl/ctlw_framer.sv
module ctlw_framer
  import ctlw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PAY_W  = 12,
  localparam int POST_W = 2 * ADDR_W + PAY_W,
  localparam int IDX_W  = $clog2(POST_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             si_i,
  output logic             row_stb_o,
  output logic             col_stb_o,
  output logic             last_o,
  output logic             match_o,
  output logic             rd_o,
  output logic             pay_phase_o,
  output logic [IDX_W-1:0] pay_idx_o
);
  localparam int HIST_W = (ADDR_W > FRAME_W) ? ADDR_W : FRAME_W;
  localparam logic [IDX_W-1:0] IDX_ROW  = IDX_W'(ADDR_W - 1);
  localparam logic [IDX_W-1:0] IDX_COL  = IDX_W'(2 * ADDR_W - 1);
  localparam logic [IDX_W-1:0] IDX_PAY  = IDX_W'(2 * ADDR_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(POST_W - 1);

  logic [HIST_W-1:0] hist_q, hist_d, hist_sh;
  logic              inw_q, inw_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  word_kind_e        kind_q, kind_d;
  logic              rowz_q, rowz_d;
  logic              match_q, match_d;
  logic              frm_wr, frm_rd;

  assign hist_sh = {hist_q[HIST_W-2:0], si_i};
  assign frm_wr  = (hist_sh[FRAME_W-1:0] == FRM_WR);
  assign frm_rd  = (hist_sh[FRAME_W-1:0] == FRM_RD);

  // next-state
  always_comb begin
    hist_d  = hist_q;
    inw_d   = inw_q;
    idx_d   = idx_q;
    kind_d  = kind_q;
    rowz_d  = rowz_q;
    match_d = match_q;
    if (en_i) begin
      hist_d = hist_sh;
      if (inw_q) begin
        if (idx_q == IDX_ROW) rowz_d = (hist_sh[ADDR_W-1:0] == '0);
        if (idx_q == IDX_COL) match_d = rowz_q && (hist_sh[ADDR_W-1:0] == '0);
        if (idx_q == IDX_LAST) begin
          inw_d   = 1'b0;
          idx_d   = '0;
          kind_d  = KIND_WR;
          rowz_d  = 1'b0;
          match_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else if (frm_wr || frm_rd) begin
        inw_d  = 1'b1;
        idx_d  = '0;
        kind_d = frm_rd ? KIND_RD : KIND_WR;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      inw_q   <= 1'b0;
      idx_q   <= '0;
      kind_q  <= KIND_WR;
      rowz_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      inw_q   <= inw_d;
      idx_q   <= idx_d;
      kind_q  <= kind_d;
      rowz_q  <= rowz_d;
      match_q <= match_d;
    end
  end

  assign row_stb_o   = en_i && inw_q && (idx_q == IDX_ROW);
  assign col_stb_o   = en_i && inw_q && (idx_q == IDX_COL);
  assign last_o      = inw_q && (idx_q == IDX_LAST);
  assign match_o     = match_q;
  assign rd_o        = (kind_q == KIND_RD);
  assign pay_phase_o = inw_q && match_q && (idx_q >= IDX_PAY);
  assign pay_idx_o   = idx_q - IDX_PAY;

  // R1: an accepted start pattern opens a word at index zero
  p_frame_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !inw_q && (frm_wr || frm_rd) |=> inw_q && (idx_q == '0));
  // R2: the word closes right after its 24th post-frame bit
  p_word_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && inw_q && (idx_q == IDX_LAST) |=> !inw_q);
  // R2: the bit index never runs past the word
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inw_q |-> (idx_q <= IDX_LAST));
  // R6: an address match only exists inside a word
  p_match_in_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> inw_q);
endmodule

// File: rtl/ctlw_lane.sv
module ctlw_lane #(
  parameter int LAT    = 7,
  parameter int ADDR_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_i,
  input  logic dec_i,
  output logic so_o
);
  // LAT must exceed ADDR_W so a whole address field is still inside
  // the pipe when its last bit arrives.
  logic [LAT-1:0] pipe_q, pipe_d, sh;

  always_comb begin
    sh = {pipe_q[LAT-2:0], bit_i};
    if (dec_i) sh[ADDR_W-1:0] = sh[ADDR_W-1:0] - 1'b1;
    pipe_d = en_i ? sh : pipe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign so_o = pipe_q[LAT-1];
endmodule

// File: rtl/ctlw_loadreg.sv
module ctlw_loadreg #(
  parameter int PAY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             si_i,
  input  logic             cap_i,
  input  logic             done_i,
  output logic [PAY_W-1:0] ld_o,
  output logic             rdy_o
);
  logic [PAY_W-1:0] shd_q, shd_d, ld_q, ld_d;
  logic [1:0]       pend_q, pend_d;
  logic             rdy_q, rdy_d;

  always_comb begin
    shd_d  = cap_i ? {shd_q[PAY_W-2:0], si_i} : shd_q;
    pend_d = pend_q;
    rdy_d  = rdy_q;
    ld_d   = ld_q;
    if (en_i) begin
      pend_d = {pend_q[0], done_i};
      rdy_d  = pend_q[1];
      if (pend_q[1]) ld_d = shd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= '0;
      pend_q <= '0;
      rdy_q  <= 1'b0;
      ld_q   <= '0;
    end else begin
      shd_q  <= shd_d;
      pend_q <= pend_d;
      rdy_q  <= rdy_d;
      ld_q   <= ld_d;
    end
  end

  assign ld_o  = ld_q;
  assign rdy_o = rdy_q;

  // R7: the load register never moves without the ready pulse
  p_ld_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ld_q) |-> rdy_q);
endmodule

// File: rtl/cascade_ctl_engine.sv
module cascade_ctl_engine #(
  parameter int ADDR_W = 6,
  parameter int CODE_W = 3,
  parameter int N_OUT  = 4,
  parameter int LAT    = 7
) (
  input  logic                    sclk,
  input  logic                    rst_n,
  input  logic                    mode_i,
  input  logic                    si,
  input  logic [CODE_W*N_OUT-1:0] cfg_i,
  output logic                    row_so,
  output logic                    row_sclk,
  output logic                    col_so,
  output logic                    col_sclk,
  output logic [CODE_W*N_OUT-1:0] ld_word,
  output logic                    ld_rdy
);
  localparam int PAY_W  = CODE_W * N_OUT;
  localparam int POST_W = 2 * ADDR_W + PAY_W;
  localparam int IDX_W  = $clog2(POST_W);
  localparam int N_PORT = 2;

  logic             en;
  logic             row_stb, col_stb, last, match, rd, pay_phase;
  logic [IDX_W-1:0] pay_idx;
  logic [PAY_W-1:0] cfg_sh;
  logic             ins_en, lane_in, cap, done;
  logic [N_PORT-1:0] dec_stb, lane_so;

  assign en = ~mode_i;

  ctlw_framer #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_frm (
    .clk(sclk), .rst_n(rst_n), .en_i(en), .si_i(si),
    .row_stb_o(row_stb), .col_stb_o(col_stb), .last_o(last),
    .match_o(match), .rd_o(rd), .pay_phase_o(pay_phase), .pay_idx_o(pay_idx)
  );

  // read-back: configuration replaces the code bits, MSB first
  assign cfg_sh  = cfg_i << pay_idx;
  assign ins_en  = pay_phase && rd;
  assign lane_in = ins_en ? cfg_sh[PAY_W-1] : si;

  assign cap  = en && pay_phase && !rd;
  assign done = en && last && match && !rd;

  // port 0 goes along the row (column field reduced),
  // port 1 goes down the column (row field reduced)
  assign dec_stb[0] = col_stb;
  assign dec_stb[1] = row_stb;

  for (genvar p = 0; p < N_PORT; p++) begin : g_lane
    ctlw_lane #(.LAT(LAT), .ADDR_W(ADDR_W)) u_lane (
      .clk(sclk), .rst_n(rst_n), .en_i(en), .bit_i(lane_in),
      .dec_i(dec_stb[p]), .so_o(lane_so[p])
    );
  end

  ctlw_loadreg #(.PAY_W(PAY_W)) u_ld (
    .clk(sclk), .rst_n(rst_n), .en_i(en), .si_i(si),
    .cap_i(cap), .done_i(done), .ld_o(ld_word), .rdy_o(ld_rdy)
  );

  assign row_so   = lane_so[0];
  assign col_so   = lane_so[1];
  assign row_sclk = sclk & en;
  assign col_sclk = sclk & en;

  // R9: a frozen edge changes no output
  p_freeze_r9: assert property (@(posedge sclk) disable iff (!rst_n)
    mode_i |=> $stable(row_so) && $stable(col_so) && $stable(ld_word) && $stable(ld_rdy));
endmodule

// File: tb/sim_cascade_ctl_engine.sv
module sim_cascade_ctl_engine;
  logic        sclk = 1'b0;
  logic        rst_n, mode, si;
  logic [11:0] cfg;
  logic        row_so, row_sclk, col_so, col_sclk, ld_rdy;
  logic [11:0] ld_word;

  cascade_ctl_engine u0 (
    .sclk(sclk), .rst_n(rst_n), .mode_i(mode), .si(si), .cfg_i(cfg),
    .row_so(row_so), .row_sclk(row_sclk), .col_so(col_so), .col_sclk(col_sclk),
    .ld_word(ld_word), .ld_rdy(ld_rdy)
  );

  always #10 sclk = ~sclk;  // 50 MHz

  int    checks = 0, fails = 0;
  string tag = "R10";

  // behavioural reference model
  bit rexp [0:8191];
  bit cexp [0:8191];
  int nen = 0, hist = 0, inw = 0, cnt = 0, rd = 0, rowz = 0, mt = 0;
  int shadow = 0, ld_due = -100, ld_pend = 0, ld_cur = 0;
  int lfsr = 16'hACE1;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit b);
    int nh, v, cb;
    nen++;
    rexp[nen] = b;
    cexp[nen] = b;
    nh = ((hist << 1) | b) & 63;
    if (inw != 0) begin
      if (mt != 0 && cnt >= 12) begin
        if (rd != 0) begin
          cb = (cfg >> (23 - cnt)) & 1;
          rexp[nen] = cb[0];
          cexp[nen] = cb[0];
        end else begin
          shadow = ((shadow << 1) | b) & 12'hFFF;
        end
      end
      if (cnt == 5) begin   // row field complete: column port reduces it
        rowz = (nh == 0);
        v = (nh + 63) & 63;
        for (int k = 0; k < 6; k++) cexp[nen-k] = v[k];
      end
      if (cnt == 11) begin  // column field complete: row port reduces it
        mt = (rowz != 0 && nh == 0);
        v = (nh + 63) & 63;
        for (int k = 0; k < 6; k++) rexp[nen-k] = v[k];
      end
      if (cnt == 23) begin
        if (rd == 0 && mt != 0) begin
          ld_due  = nen + 2;
          ld_pend = shadow;
        end
        inw = 0; mt = 0; rd = 0; rowz = 0; cnt = 0;
      end else begin
        cnt++;
      end
    end else if (nh == 31 || nh == 30) begin
      inw = 1; cnt = 0; rd = (nh == 30);
    end
    hist = nh;
    if (nen == ld_due) ld_cur = ld_pend;
  endtask

  task automatic check_outs();
    int k, er, ec;
    k  = nen - 6;
    er = (k >= 1) ? int'(rexp[k]) : 0;
    ec = (k >= 1) ? int'(cexp[k]) : 0;
    chk("R5 row port data", row_so, er);
    chk("R4 column port data", col_so, ec);
    chk("R6 load register", ld_word, ld_cur);
    chk("R6 load ready", ld_rdy, (nen == ld_due) ? 1 : 0);
  endtask

  task automatic tick(bit b, bit m);
    si   = b;
    mode = m;
    if (!m) model_step(b);
    @(posedge sclk);
    #5;
    chk("R3 R9 row forwarded clock", row_sclk, m ? 0 : 1);
    chk("R3 R9 column forwarded clock", col_sclk, m ? 0 : 1);
    @(negedge sclk);
    check_outs();
  endtask

  task automatic send_word(logic [5:0] f, logic [5:0] r, logic [5:0] c,
                           logic [11:0] p, int frz_at, int frz_len);
    logic [29:0] w;
    w = {f, r, c, p};
    for (int i = 29; i >= 0; i--) begin
      if (i == frz_at)
        for (int j = 0; j < frz_len; j++) tick(j[0], 1'b1);  // ignored bits
      tick(w[i], 1'b0);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0; si = 1'b0; cfg = 12'h000;
    repeat (3) @(negedge sclk);
    // R10: reset state
    chk("R10 row data in reset", row_so, 0);
    chk("R10 column data in reset", col_so, 0);
    chk("R10 load register in reset", ld_word, 0);
    chk("R10 ready in reset", ld_rdy, 0);
    rst_n = 1'b1;

    // R1: near-miss patterns do not open a word, then a real write
    tag = "R1";
    idle(8);
    for (int i = 11; i >= 0; i--) tick(bit'((12'b011101011100 >> i) & 1), 1'b0);
    for (int i = 3; i >= 0; i--) tick(bit'((4'b1100 >> i) & 1), 1'b0);
    tag = "R6";
    send_word(6'b011111, 6'd0, 6'd0, 12'h29C, -1, 0);
    idle(10);

    // R7: words for other devices leave the load register alone
    tag = "R7";
    send_word(6'b011111, 6'd0, 6'd2, 12'hFFF, -1, 0);
    send_word(6'b011111, 6'd1, 6'd0, 12'h111, -1, 0);
    idle(6);

    // R4 R5: both address fields reduced on their own ports
    tag = "R4 R5";
    send_word(6'b011111, 6'd5, 6'd7, 12'h5A5, -1, 0);
    send_word(6'b011111, 6'd0, 6'd40, 12'h0C3, -1, 0);
    idle(6);

    // R2: start pattern inside payload, back-to-back words
    tag = "R2";
    send_word(6'b011111, 6'd0, 6'd0, 12'b011111011110, -1, 0);
    send_word(6'b011111, 6'd0, 6'd0, 12'h0F0, -1, 0);
    idle(8);

    // R8: matching read inserts configuration, then a write works again
    tag = "R8";
    cfg = 12'hA5C;
    send_word(6'b011110, 6'd0, 6'd0, 12'h000, -1, 0);
    send_word(6'b011111, 6'd0, 6'd0, 12'h3C3, -1, 0);
    idle(4);
    send_word(6'b011110, 6'd0, 6'd1, 12'hFFF, -1, 0);
    idle(8);

    // R9: freeze inside a word and inside the load delay
    tag = "R9";
    send_word(6'b011111, 6'd0, 6'd0, 12'h812, 14, 5);
    tick(1'b0, 1'b0);
    for (int j = 0; j < 4; j++) tick(1'b1, 1'b1);
    idle(10);

    // R1 R3: pseudo-random stream against the model
    tag = "R1 R3";
    cfg = 12'h6B1;
    for (int i = 0; i < 400; i++) begin
      lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      tick(bit'(lfsr & 1), 1'b0);
    end
    idle(10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule